// File: doc/BRIEF.md
# Processor Reset Exception Controller

This block decides what kind of reset the processor core is coming out of and prepares the control state for the first instruction fetch. While the active-low reset pin is held, it watches the active-low bus grant pin. If grant is low in any cycle together with reset, the event is a power-on (cold) reset; if grant stays high for the whole reset interval, it is a soft reset. While reset is held, the block also shifts in a serial stream of boot-mode bits, one bit per clock, least significant bit first.

On the first clock edge after the reset pin returns high, a cold reset loads a fixed subset of control-coprocessor fields with defined values. It copies the current program counter into the error return register, raises a one-cycle fetch redirect towards the boot vector, and raises a one-cycle pulse that clears pending cache errors, delayed watch events and external interrupts. A soft reset raises only its own one-cycle indication and leaves every field alone. No enable bit can suppress the cold reset path. The `rst` input is the synchronous, active-high reset of the block's own flops.

Top module: `rex_top`

## Requirements
- R1: A reset interval (reset pin low for one or more cycles) in which the grant pin is low in at least one cycle is a cold reset. On the first clock edge where the reset pin is sampled high after such an interval, `redirect_o` and `clr_pend_o` are both high for exactly one cycle.
- R2: A reset interval in which the grant pin stays high is a soft reset. It gives a one-cycle pulse on `soft_o`, no pulse on `redirect_o` or `clr_pend_o`, and leaves all field outputs unchanged.
- R3: On a cold reset, `target_o` becomes 0x00000000_BFC00000 when `mode64_i` is 0 and 0xFFFFFFFF_BFC00000 when it is 1, sampled on the same edge. It holds that value until the next cold reset.
- R4: On a cold reset, `status_o` is set to `stat_cur_i` with bit 2 (error level) and bit 22 (boot vectors) set to 1, and bit 20 (soft-reset flag) and bit 21 (TLB shutdown) cleared to 0. Every other bit is copied unchanged.
- R5: On a cold reset, `errpc_o` captures the value of `pc_i` sampled on the same edge.
- R6: On a cold reset, `random_o` becomes RAND_MAX (63 by default). `wired_o`, `fmask_o`, `pcev_o`, `bpred_o` and the cache-error bit `ew_o` all become 0.
- R7: On a cold reset, `config_o` bit i holds the serial bit sampled on the (i+1)-th clock edge of the reset interval. Bits beyond BOOT_BITS are ignored, and bits that were never received read 0.
- R8: While the reset pin is low, no pulse is raised on `redirect_o`, `clr_pend_o` or `soft_o`, and the field outputs keep their values.
- R9: After `rst`: all pulses are low, `target_o`, `status_o`, `errpc_o`, `config_o` and `random_o` are 0, and `wired_o`, `fmask_o`, `pcev_o`, `bpred_o` and `ew_o` are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's flops |
| rst_pin_n | input | 1 | Active-low processor reset pin |
| gnt_pin_n | input | 1 | Active-low bus grant pin |
| pc_i | input | 64 | Current program counter |
| mode64_i | input | 1 | 1 selects 64-bit addressing |
| boot_sdi | input | 1 | Serial boot-mode bit, one per clock during reset |
| stat_cur_i | input | 32 | Current status register value |
| status_o | output | 32 | Status register after initialisation |
| config_o | output | BOOT_BITS | Captured boot-mode configuration |
| errpc_o | output | 64 | Error return PC |
| random_o | output | IDX_W | TLB random index |
| wired_o | output | IDX_W | TLB wired boundary |
| fmask_o | output | FM_W | Frame mask field |
| pcev_o | output | EV_W | Performance counter event selector |
| bpred_o | output | BP_W | Branch prediction bits |
| ew_o | output | 1 | Cache-error EW bit |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| target_o | output | 64 | Fetch redirect target |
| clr_pend_o | output | 1 | One-cycle clear of pending events |
| soft_o | output | 1 | One-cycle soft reset indication |

## Verification
The bench drives cold resets with grant low for the whole interval and with grant low for a single cycle in the middle, soft resets with grant always high, and a cold reset that follows a soft one directly. A design that sampled grant only on the last reset cycle would misclassify the mid-interval case, and one that kept the cold flag across intervals would turn a later soft reset into a cold one. Boot streams longer and shorter than BOOT_BITS expose a capture that keeps shifting past the field width or keeps stale bits from a previous reset. Random status and PC values, sampled exactly on the release edge, catch an off-by-one capture cycle or a status mask that touches bits it should leave alone.

// File: rtl/rex_pkg.sv
package rex_pkg;
    localparam logic [31:0] VEC_LO = 32'hBFC0_0000;
    localparam int ST_ERL = 2;
    localparam int ST_SR  = 20;
    localparam int ST_TS  = 21;
    localparam int ST_BEV = 22;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_COLD = 2'd1,
        RK_SOFT = 2'd2
    } rst_kind_e;

    function automatic logic [63:0] boot_vector(input logic m64);
        return m64 ? {32'hFFFF_FFFF, VEC_LO} : {32'h0000_0000, VEC_LO};
    endfunction

    function automatic logic [31:0] status_init(input logic [31:0] cur);
        logic [31:0] s;
        s = cur;
        s[ST_ERL] = 1'b1;
        s[ST_BEV] = 1'b1;
        s[ST_SR]  = 1'b0;
        s[ST_TS]  = 1'b0;
        return s;
    endfunction
endpackage

// File: rtl/rex_classify.sv
module rex_classify
    import rex_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rst_pin_n,
    input  logic      gnt_pin_n,
    output logic      first_o,
    output rst_kind_e kind_o
);
    logic held_q;
    logic cold_q;

    assign first_o = !rst_pin_n && !held_q;

    always_comb begin
        kind_o = RK_NONE;
        if (rst_pin_n && held_q) begin
            kind_o = cold_q ? RK_COLD : RK_SOFT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            cold_q <= 1'b0;
        end else if (!rst_pin_n) begin
            held_q <= 1'b1;
            cold_q <= first_o ? !gnt_pin_n : (cold_q || !gnt_pin_n);
        end else begin
            held_q <= 1'b0;
            cold_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rex_bootcap.sv
module rex_bootcap #(
    parameter int BOOT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 first,
    input  logic                 sdi,
    output logic [BOOT_BITS-1:0] bits_o
);
    localparam int CW = $clog2(BOOT_BITS + 1);
    localparam int IW = $clog2(BOOT_BITS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_o <= '0;
            cnt_q  <= '0;
        end else if (active) begin
            if (first) begin
                bits_o <= {{(BOOT_BITS-1){1'b0}}, sdi};
                cnt_q  <= CW'(1);
            end else if (cnt_q < CW'(BOOT_BITS)) begin
                bits_o[cnt_q[IW-1:0]] <= sdi;
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rex_cp0init.sv
module rex_cp0init
    import rex_pkg::*;
#(
    parameter int BOOT_BITS = 8,
    parameter int RAND_MAX  = 63,
    parameter int FM_W      = 4,
    parameter int EV_W      = 5,
    parameter int BP_W      = 16,
    localparam int IDX_W    = $clog2(RAND_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rst_kind_e            kind,
    input  logic [63:0]          pc_i,
    input  logic                 mode64_i,
    input  logic [31:0]          stat_cur_i,
    input  logic [BOOT_BITS-1:0] boot_bits,
    output logic [31:0]          status_o,
    output logic [BOOT_BITS-1:0] config_o,
    output logic [63:0]          errpc_o,
    output logic [IDX_W-1:0]     random_o,
    output logic [IDX_W-1:0]     wired_o,
    output logic [FM_W-1:0]      fmask_o,
    output logic [EV_W-1:0]      pcev_o,
    output logic [BP_W-1:0]      bpred_o,
    output logic                 ew_o,
    output logic                 redirect_o,
    output logic [63:0]          target_o,
    output logic                 clr_pend_o,
    output logic                 soft_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_o   <= '0;
            config_o   <= '0;
            errpc_o    <= '0;
            random_o   <= '0;
            wired_o    <= '1;
            fmask_o    <= '1;
            pcev_o     <= '1;
            bpred_o    <= '1;
            ew_o       <= 1'b1;
            redirect_o <= 1'b0;
            target_o   <= '0;
            clr_pend_o <= 1'b0;
            soft_o     <= 1'b0;
        end else begin
            redirect_o <= (kind == RK_COLD);
            clr_pend_o <= (kind == RK_COLD);
            soft_o     <= (kind == RK_SOFT);
            if (kind == RK_COLD) begin
                status_o <= status_init(stat_cur_i);
                config_o <= boot_bits;
                errpc_o  <= pc_i;
                random_o <= IDX_W'(RAND_MAX);
                wired_o  <= '0;
                fmask_o  <= '0;
                pcev_o   <= '0;
                bpred_o  <= '0;
                ew_o     <= 1'b0;
                target_o <= boot_vector(mode64_i);
            end
        end
    end
endmodule

// File: rtl/rex_top.sv
module rex_top
    import rex_pkg::*;
#(
    parameter int BOOT_BITS = 8,
    parameter int RAND_MAX  = 63,
    parameter int FM_W      = 4,
    parameter int EV_W      = 5,
    parameter int BP_W      = 16,
    localparam int IDX_W    = $clog2(RAND_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rst_pin_n,
    input  logic                 gnt_pin_n,
    input  logic [63:0]          pc_i,
    input  logic                 mode64_i,
    input  logic                 boot_sdi,
    input  logic [31:0]          stat_cur_i,
    output logic [31:0]          status_o,
    output logic [BOOT_BITS-1:0] config_o,
    output logic [63:0]          errpc_o,
    output logic [IDX_W-1:0]     random_o,
    output logic [IDX_W-1:0]     wired_o,
    output logic [FM_W-1:0]      fmask_o,
    output logic [EV_W-1:0]      pcev_o,
    output logic [BP_W-1:0]      bpred_o,
    output logic                 ew_o,
    output logic                 redirect_o,
    output logic [63:0]          target_o,
    output logic                 clr_pend_o,
    output logic                 soft_o
);
    logic                 first;
    rst_kind_e            kind;
    logic [BOOT_BITS-1:0] boot_bits;

    rex_classify u_cls (
        .clk       (clk),
        .rst       (rst),
        .rst_pin_n (rst_pin_n),
        .gnt_pin_n (gnt_pin_n),
        .first_o   (first),
        .kind_o    (kind)
    );

    rex_bootcap #(.BOOT_BITS(BOOT_BITS)) u_boot (
        .clk    (clk),
        .rst    (rst),
        .active (!rst_pin_n),
        .first  (first),
        .sdi    (boot_sdi),
        .bits_o (boot_bits)
    );

    rex_cp0init #(
        .BOOT_BITS (BOOT_BITS),
        .RAND_MAX  (RAND_MAX),
        .FM_W      (FM_W),
        .EV_W      (EV_W),
        .BP_W      (BP_W)
    ) u_init (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .pc_i       (pc_i),
        .mode64_i   (mode64_i),
        .stat_cur_i (stat_cur_i),
        .boot_bits  (boot_bits),
        .status_o   (status_o),
        .config_o   (config_o),
        .errpc_o    (errpc_o),
        .random_o   (random_o),
        .wired_o    (wired_o),
        .fmask_o    (fmask_o),
        .pcev_o     (pcev_o),
        .bpred_o    (bpred_o),
        .ew_o       (ew_o),
        .redirect_o (redirect_o),
        .target_o   (target_o),
        .clr_pend_o (clr_pend_o),
        .soft_o     (soft_o)
    );
endmodule

// File: rtl/rex_chk.sv
module rex_chk #(
    parameter int RAND_MAX = 63,
    localparam int IDX_W   = $clog2(RAND_MAX + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_pin_n,
    input logic [63:0]      pc_i,
    input logic [31:0]      status_o,
    input logic [63:0]      errpc_o,
    input logic [IDX_W-1:0] random_o,
    input logic [IDX_W-1:0] wired_o,
    input logic             redirect_o,
    input logic             clr_pend_o,
    input logic             soft_o
);
    a_r1_one_cycle_redirect: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> !redirect_o);

    a_r1_clear_follows_redirect: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> clr_pend_o);

    a_r2_soft_excludes_cold: assert property (@(posedge clk) disable iff (rst)
        soft_o |-> (!redirect_o && !clr_pend_o));

    a_r2_soft_one_cycle: assert property (@(posedge clk) disable iff (rst)
        soft_o |=> !soft_o);

    a_r4_status_bits: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (status_o[2] && status_o[22] && !status_o[20] && !status_o[21]));

    a_r5_errpc_capture: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (errpc_o == $past(pc_i)));

    a_r6_tlb_fields: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (random_o == IDX_W'(RAND_MAX) && wired_o == '0));

    a_r8_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |=> (!redirect_o && !soft_o && !clr_pend_o));
endmodule

bind rex_top rex_chk #(.RAND_MAX(RAND_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_pin_n  (rst_pin_n),
    .pc_i       (pc_i),
    .status_o   (status_o),
    .errpc_o    (errpc_o),
    .random_o   (random_o),
    .wired_o    (wired_o),
    .redirect_o (redirect_o),
    .clr_pend_o (clr_pend_o),
    .soft_o     (soft_o)
);

// File: tb/test_rex_top.sv
`timescale 1ns/1ps
module test_rex_top;
    localparam int BOOT_BITS = 8;
    localparam int RAND_MAX  = 63;
    localparam int FM_W      = 4;
    localparam int EV_W      = 5;
    localparam int BP_W      = 16;
    localparam int IDX_W     = $clog2(RAND_MAX + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin_n = 1'b1;
    logic gnt_pin_n = 1'b1;
    logic [63:0] pc_i = '0;
    logic mode64_i = 1'b0;
    logic boot_sdi = 1'b0;
    logic [31:0] stat_cur_i = '0;

    logic [31:0]          status_o;
    logic [BOOT_BITS-1:0] config_o;
    logic [63:0]          errpc_o;
    logic [IDX_W-1:0]     random_o;
    logic [IDX_W-1:0]     wired_o;
    logic [FM_W-1:0]      fmask_o;
    logic [EV_W-1:0]      pcev_o;
    logic [BP_W-1:0]      bpred_o;
    logic                 ew_o;
    logic                 redirect_o;
    logic [63:0]          target_o;
    logic                 clr_pend_o;
    logic                 soft_o;

    always #5 clk = ~clk;

    rex_top #(.BOOT_BITS(BOOT_BITS), .RAND_MAX(RAND_MAX), .FM_W(FM_W),
              .EV_W(EV_W), .BP_W(BP_W)) i_rex_top (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .gnt_pin_n(gnt_pin_n),
        .pc_i(pc_i), .mode64_i(mode64_i), .boot_sdi(boot_sdi),
        .stat_cur_i(stat_cur_i), .status_o(status_o), .config_o(config_o),
        .errpc_o(errpc_o), .random_o(random_o), .wired_o(wired_o),
        .fmask_o(fmask_o), .pcev_o(pcev_o), .bpred_o(bpred_o), .ew_o(ew_o),
        .redirect_o(redirect_o), .target_o(target_o),
        .clr_pend_o(clr_pend_o), .soft_o(soft_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int n_cold = 0;
    int n_soft = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit   m_in_reset;
    bit   m_cold;
    bit   m_boot_q[$];
    logic [31:0]          e_status;
    logic [BOOT_BITS-1:0] e_config;
    logic [63:0]          e_errpc;
    logic [IDX_W-1:0]     e_random, e_wired;
    logic [FM_W-1:0]      e_fmask;
    logic [EV_W-1:0]      e_pcev;
    logic [BP_W-1:0]      e_bpred;
    logic                 e_ew, e_redirect, e_clr, e_soft;
    logic [63:0]          e_target;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_in_reset = 0; m_cold = 0; m_boot_q.delete();
            e_status = '0; e_config = '0; e_errpc = '0; e_random = '0;
            e_wired = '1; e_fmask = '1; e_pcev = '1; e_bpred = '1; e_ew = 1'b1;
            e_redirect = 0; e_clr = 0; e_soft = 0; e_target = '0;
        end else begin
            e_redirect = 0; e_clr = 0; e_soft = 0;
            if (!rst_pin_n) begin
                if (!m_in_reset) begin
                    m_in_reset = 1;
                    m_cold = 0;
                    m_boot_q.delete();
                end
                if (!gnt_pin_n) m_cold = 1;
                m_boot_q.push_back(boot_sdi);
            end else if (m_in_reset) begin
                m_in_reset = 0;
                if (m_cold) begin
                    n_cold++;
                    e_redirect = 1; e_clr = 1;
                    e_status = stat_cur_i;
                    e_status[2] = 1'b1; e_status[22] = 1'b1;
                    e_status[20] = 1'b0; e_status[21] = 1'b0;
                    for (int i = 0; i < BOOT_BITS; i++)
                        e_config[i] = (i < m_boot_q.size()) ? m_boot_q[i] : 1'b0;
                    e_errpc = pc_i;
                    e_random = IDX_W'(RAND_MAX);
                    e_wired = '0; e_fmask = '0; e_pcev = '0; e_bpred = '0; e_ew = 1'b0;
                    e_target = mode64_i ? 64'hFFFF_FFFF_BFC0_0000 : 64'h0000_0000_BFC0_0000;
                end else begin
                    n_soft++;
                    e_soft = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            chk("R1", "redirect", 64'(redirect_o), 64'(e_redirect));
            chk("R1", "clr_pend", 64'(clr_pend_o), 64'(e_clr));
            chk("R2", "soft", 64'(soft_o), 64'(e_soft));
            chk("R3", "target", target_o, e_target);
            chk("R4", "status", 64'(status_o), 64'(e_status));
            chk("R5", "errpc", errpc_o, e_errpc);
            chk("R6", "random", 64'(random_o), 64'(e_random));
            chk("R6", "wired", 64'(wired_o), 64'(e_wired));
            chk("R6", "fmask", 64'(fmask_o), 64'(e_fmask));
            chk("R6", "pcev", 64'(pcev_o), 64'(e_pcev));
            chk("R6", "bpred", 64'(bpred_o), 64'(e_bpred));
            chk("R6", "ew", 64'(ew_o), 64'(e_ew));
            chk("R7", "config", 64'(config_o), 64'(e_config));
        end
    end

    // one reset interval; grant_mask bit k = 1 drives grant low in cycle k
    task automatic reset_seq(input int len, input logic [31:0] grant_mask,
                             input logic [31:0] boot_pat, input logic m64);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rst_pin_n  = 1'b0;
            gnt_pin_n  = !grant_mask[k];
            boot_sdi   = boot_pat[k];
            pc_i       = {$urandom, $urandom};
            stat_cur_i = $urandom;
            mode64_i   = $urandom_range(0, 1);
        end
        @(negedge clk);
        rst_pin_n  = 1'b1;
        gnt_pin_n  = 1'b1;
        boot_sdi   = $urandom_range(0, 1);
        pc_i       = {$urandom, $urandom};
        stat_cur_i = $urandom;
        mode64_i   = m64;
        repeat (3) begin
            @(negedge clk);
            pc_i = {$urandom, $urandom};
            stat_cur_i = $urandom;
            mode64_i = $urandom_range(0, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state is compared on every cycle above
        @(negedge clk);
        chk("R9", "reset random", 64'(random_o), 64'd0);
        chk("R9", "reset bpred", 64'(bpred_o), 64'(16'hFFFF));
        // R1 R3 R7: cold, grant low throughout, 32-bit, long boot stream
        reset_seq(11, 32'hFFFF_FFFF, 32'h0000_02B5, 1'b0);
        // R2: soft reset, grant high, fields untouched
        reset_seq(6, 32'h0, 32'h0000_003F, 1'b1);
        // R1 R3: cold with grant low only mid-interval, 64-bit
        reset_seq(9, 32'h0000_0010, 32'h0000_01C3, 1'b1);
        // R7: short interval, untouched high config bits read 0
        reset_seq(3, 32'h0000_0001, 32'h0000_0007, 1'b0);
        // R2 then cold back to back
        reset_seq(1, 32'h0, 32'h1, 1'b0);
        reset_seq(1, 32'h1, 32'h1, 1'b1);
        // R8: long interval with grant low at the last cycle
        reset_seq(20, 32'h0008_0000, 32'hA5A5_5A5A, 1'b0);
        for (int n = 0; n < 20; n++)
            reset_seq($urandom_range(1, 12), $urandom, $urandom, $urandom_range(0, 1));
        checks++;
        if (n_cold < 6 || n_soft < 2) begin
            errors++;
            $display("FAIL R1 scenario coverage actual=%0d/%0d expected>=6/2", n_cold, n_soft);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule